// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block holds several independent 32-bit countdown channels behind a small synchronous register port. Each channel has a reload value, a live counter and a 16-bit control word. The control word chooses a divided tick of the peripheral clock, enables an interrupt and holds a sticky underflow flag. A single shared start register has one run bit for each channel. While a channel runs, its counter drops by one on every selected tick. When a tick arrives with the counter at zero, the counter is refilled from the reload value and counting goes on. A channel therefore repeats with a period of reload+1 ticks. With a reload of all ones it runs almost freely, and the inverse of the counter then gives the number of elapsed ticks.

Each channel is managed by a two-state machine. In `CH_HALT` the prescaler is held at zero and the counter does not move. In `CH_RUN` the prescaler advances and sends ticks to the counter. The transition `start` (HALT to RUN) fires when a start-register write leaves the channel's bit at 1. The transition `stop` (RUN to HALT) fires when such a write leaves the bit at 0. Every other case keeps the current state. The run bit read back from the start register is this state. Each channel drives one interrupt output, which is high while both its flag and its enable are set.

Software controls the unit with single-cycle accesses. It loads the reload value and the counter, writes the control word, and then sets the run bit. Software clears the flag by writing the control word with bit 8 at 0.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset every register reads 0, every channel is in `CH_HALT`, and all interrupt outputs are low.
- R2: The start register sits at byte offset 4, and its bit n is the run bit of channel n. Channel n occupies offsets 8+12n (reload, 32 bits), 12+12n (counter, 32 bits) and 16+12n (control, 16 bits). Any other offset reads 0, and writes to it are dropped.
- R3: The access width is set by `bus_size`: 0 selects a byte, 1 a halfword, 2 or 3 a word. The byte lane comes from `bus_addr[1:0]`, and a halfword uses lane pair `bus_addr[1]`. Write data is taken from the low bits of `bus_wdata`. Read data comes back in the low bits of `bus_rdata` and is zero-extended.
- R4: Control bits [2:0] set the tick period. Codes 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024 clocks. The first tick after a `start` lands exactly one period of edges after the starting write edge.
- R5: Prescaler codes 5, 6 and 7 produce no ticks, so the counter holds even while the channel runs.
- R6: On each tick of a running channel the counter decreases by one. A halted channel keeps its counter, and software can write it freely. With reload and counter both at 0xFFFFFFFF, the inverse of the counter equals the number of ticks since start.
- R7: When a tick arrives with the counter at 0, the counter loads the reload value in the same edge and control bit 8 (flag) is set.
- R8: The flag stays set until a control write leaves bit 8 at 0. Writing 1 to bit 8, or making a write that does not cover byte lane 1, leaves the flag unchanged.
- R9: Control bit 5 is the interrupt enable. Output `irq[n]` is high exactly while channel n has both its flag and its enable set.
- R10: Each channel's prescaler phase is cleared on `start`. A partial period that was counted before a `stop` does not carry over.
- R11: Channels are independent. Start-register bits at NUM_CH and above read 0. Activity on one channel never changes another channel's `irq` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, combinational, low-aligned |
| irq | output | NUM_CH | Per-channel underflow interrupt |

## Verification
The hardest case to reach is the exact edge of an underflow at the slow prescaler settings. At that edge the counter wraps, the flag rises and the interrupt goes high, all in one cycle, and only after up to a thousand clocks per tick. The bench sweeps every channel through every valid code. It loads a small counter and reload so that the wrap happens within a few ticks, and it samples one cycle before and exactly at the computed wrap edge. A separate stop-and-restart sequence checks that the prescaler phase really is discarded.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int BUS_W   = 32;
    localparam int PSC_W   = 10;
    localparam int CODE_W  = 3;
    localparam int CTRL_W  = 16;
    localparam int FLAG_B  = 8;
    localparam int IE_B    = 5;

    typedef enum logic [0:0] {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // Merge low-aligned write data into an old word using size and lane.
    function automatic logic [BUS_W-1:0] lane_merge(
        input logic [BUS_W-1:0] old_v,
        input logic [BUS_W-1:0] wd,
        input logic [1:0]       sz,
        input logic [1:0]       lane
    );
        logic [3:0]       be;
        logic [BUS_W-1:0] rep;
        logic [BUS_W-1:0] res;
        case (sz)
            2'd0: begin
                be  = 4'b0001 << lane;
                rep = {4{wd[7:0]}};
            end
            2'd1: begin
                be  = lane[1] ? 4'b1100 : 4'b0011;
                rep = {2{wd[15:0]}};
            end
            default: begin
                be  = 4'b1111;
                rep = wd;
            end
        endcase
        for (int b = 0; b < 4; b++) begin
            res[8*b +: 8] = be[b] ? rep[8*b +: 8] : old_v[8*b +: 8];
        end
        return res;
    endfunction

    // Pick the addressed part of a word and return it low-aligned.
    function automatic logic [BUS_W-1:0] lane_extract(
        input logic [BUS_W-1:0] v,
        input logic [1:0]       sz,
        input logic [1:0]       lane
    );
        logic [BUS_W-1:0] sh;
        case (sz)
            2'd0: begin
                sh = v >> {lane, 3'b000};
                return {24'b0, sh[7:0]};
            end
            2'd1: begin
                sh = lane[1] ? (v >> 16) : v;
                return {16'b0, sh[15:0]};
            end
            default: return v;
        endcase
    endfunction

    function automatic logic code_ok(input logic [CODE_W-1:0] code);
        return code <= 3'd4;
    endfunction

    // Last prescaler phase before a tick: period minus one.
    function automatic logic [PSC_W-1:0] psc_last(input logic [CODE_W-1:0] code);
        logic [PSC_W:0] period;
        period = (PSC_W+1)'(4) << {code[1:0], 1'b0};
        if (code[2]) period = (PSC_W+1)'(1024);
        return PSC_W'(period - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_chan_ctrl.sv
`timescale 1ns/1ps
module tmr_chan_ctrl
    import tmr_pkg::*;
#(
    parameter int PSC_BITS = PSC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic [CODE_W-1:0] psc_code,
    output logic              running,
    output logic              tick
);

    ch_state_e           state_q, state_d;
    logic [PSC_BITS-1:0] phase_q;
    logic [PSC_BITS-1:0] last_phase;

    assign last_phase = PSC_BITS'(psc_last(psc_code));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (start_req) state_d = CH_RUN;
            CH_RUN:  if (stop_req)  state_d = CH_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // Output process: tick strobe and run status.
    always_comb begin
        running = 1'b0;
        tick    = 1'b0;
        unique case (state_q)
            CH_HALT: ;
            CH_RUN: begin
                running = 1'b1;
                tick    = code_ok(psc_code) && (phase_q >= last_phase);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (state_q == CH_HALT || stop_req) begin
            phase_q <= '0;
        end else if (!code_ok(psc_code)) begin
            phase_q <= phase_q;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_we,
    input  logic              count_we,
    input  logic              ctrl_we,
    input  logic [1:0]        wr_size,
    input  logic [1:0]        wr_lane,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              start_req,
    input  logic              stop_req,
    output logic [BUS_W-1:0]  reload_q,
    output logic [BUS_W-1:0]  count_q,
    output logic [CTRL_W-1:0] ctrl_v,
    output logic [CODE_W-1:0] psc_q,
    output logic              running,
    output logic              tick,
    output logic              flag_q,
    output logic              irq
);

    logic              ie_q;
    logic [BUS_W-1:0]  ctrl_new;
    logic              unused_ctrl_bits;

    assign ctrl_v   = {7'b0, flag_q, 2'b0, ie_q, 2'b0, psc_q};
    assign ctrl_new = lane_merge({{(BUS_W-CTRL_W){1'b0}}, ctrl_v}, wr_data, wr_size, wr_lane);
    assign unused_ctrl_bits = ^{ctrl_new[BUS_W-1:FLAG_B+1], ctrl_new[FLAG_B-1:IE_B+1],
                                ctrl_new[IE_B-1:CODE_W]};

    tmr_chan_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .psc_code  (psc_q),
        .running   (running),
        .tick      (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (reload_we) begin
            reload_q <= lane_merge(reload_q, wr_data, wr_size, wr_lane);
        end
    end

    // Bus write wins over a tick in the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (count_we) begin
            count_q <= lane_merge(count_q, wr_data, wr_size, wr_lane);
        end else if (tick) begin
            count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
        end
    end

    // Underflow set wins over a software clear in the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
            psc_q  <= '0;
        end else begin
            if (ctrl_we) begin
                ie_q  <= ctrl_new[IE_B];
                psc_q <= ctrl_new[CODE_W-1:0];
            end
            if (tick && count_q == '0)
                flag_q <= 1'b1;
            else if (ctrl_we)
                flag_q <= flag_q & ctrl_new[FLAG_B];
        end
    end

    assign irq = flag_q & ie_q;

endmodule

// File: rtl/tmr_regmux.sv
`timescale 1ns/1ps
module tmr_regmux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 6
) (
    input  logic                           bus_valid,
    input  logic                           bus_write,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [1:0]                     bus_size,
    input  logic [NUM_CH-1:0][BUS_W-1:0]   reload_v,
    input  logic [NUM_CH-1:0][BUS_W-1:0]   count_v,
    input  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_v,
    input  logic [NUM_CH-1:0]              run_v,
    output logic [NUM_CH-1:0]              reload_we,
    output logic [NUM_CH-1:0]              count_we,
    output logic [NUM_CH-1:0]              ctrl_we,
    output logic                           start_we,
    output logic [BUS_W-1:0]               rdata
);

    localparam int WIDX_W    = ADDR_W - 2;
    localparam int START_IDX = 1;

    logic [WIDX_W-1:0]        widx;
    logic                     wr_go;
    logic [NUM_CH-1:0][BUS_W-1:0] ch_word;
    logic [NUM_CH-1:0]        ch_hit;
    logic [BUS_W-1:0]         start_word;
    logic [BUS_W-1:0]         sel_word;

    assign widx  = bus_addr[ADDR_W-1:2];
    assign wr_go = bus_valid & bus_write;

    assign start_we = wr_go && (widx == WIDX_W'(START_IDX));

    always_comb begin
        start_word = '0;
        start_word[NUM_CH-1:0] = run_v;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        localparam int BASE_IDX = 2 + 3 * g;
        logic hit_rld, hit_cnt, hit_ctl;
        assign hit_rld = (widx == WIDX_W'(BASE_IDX));
        assign hit_cnt = (widx == WIDX_W'(BASE_IDX + 1));
        assign hit_ctl = (widx == WIDX_W'(BASE_IDX + 2));

        assign reload_we[g] = wr_go & hit_rld;
        assign count_we[g]  = wr_go & hit_cnt;
        assign ctrl_we[g]   = wr_go & hit_ctl;

        assign ch_hit[g] = hit_rld | hit_cnt | hit_ctl;
        always_comb begin
            ch_word[g] = '0;
            if (hit_rld)      ch_word[g] = reload_v[g];
            else if (hit_cnt) ch_word[g] = count_v[g];
            else if (hit_ctl) ch_word[g] = {{(BUS_W-CTRL_W){1'b0}}, ctrl_v[g]};
        end
    end

    always_comb begin
        sel_word = '0;
        if (widx == WIDX_W'(START_IDX)) sel_word = start_word;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) sel_word = ch_word[c];
        end
        rdata = (bus_valid && !bus_write) ? lane_extract(sel_word, bus_size, bus_addr[1:0]) : '0;
    end

endmodule

// File: rtl/tick_timer_unit.sv
`timescale 1ns/1ps
module tick_timer_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0][BUS_W-1:0]  ch_reload;
    logic [NUM_CH-1:0][BUS_W-1:0]  ch_count;
    logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_psc;
    logic [NUM_CH-1:0]             ch_run;
    logic [NUM_CH-1:0]             ch_tick;
    logic [NUM_CH-1:0]             ch_flag;
    logic [NUM_CH-1:0]             ch_rld_we;
    logic [NUM_CH-1:0]             ch_cnt_we;
    logic [NUM_CH-1:0]             ch_ctrl_we;
    logic                          start_we;
    logic [BUS_W-1:0]              start_new;
    logic [BUS_W-1:0]              start_old;
    logic                          unused_start_bits;

    tmr_regmux #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regmux (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .reload_v  (ch_reload),
        .count_v   (ch_count),
        .ctrl_v    (ch_ctrl),
        .run_v     (ch_run),
        .reload_we (ch_rld_we),
        .count_we  (ch_cnt_we),
        .ctrl_we   (ch_ctrl_we),
        .start_we  (start_we),
        .rdata     (bus_rdata)
    );

    always_comb begin
        start_old = '0;
        start_old[NUM_CH-1:0] = ch_run;
    end
    assign start_new = lane_merge(start_old, bus_wdata, bus_size, bus_addr[1:0]);
    assign unused_start_bits = ^start_new[BUS_W-1:NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .reload_we (ch_rld_we[g]),
            .count_we  (ch_cnt_we[g]),
            .ctrl_we   (ch_ctrl_we[g]),
            .wr_size   (bus_size),
            .wr_lane   (bus_addr[1:0]),
            .wr_data   (bus_wdata),
            .start_req (start_we &  start_new[g]),
            .stop_req  (start_we & ~start_new[g]),
            .reload_q  (ch_reload[g]),
            .count_q   (ch_count[g]),
            .ctrl_v    (ch_ctrl[g]),
            .psc_q     (ch_psc[g]),
            .running   (ch_run[g]),
            .tick      (ch_tick[g]),
            .flag_q    (ch_flag[g]),
            .irq       (irq[g])
        );
    end

endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0][BUS_W-1:0]  count,
    input logic [NUM_CH-1:0][BUS_W-1:0]  reload,
    input logic [NUM_CH-1:0][CODE_W-1:0] psc,
    input logic [NUM_CH-1:0]             run,
    input logic [NUM_CH-1:0]             tick,
    input logic [NUM_CH-1:0]             flag,
    input logic [NUM_CH-1:0]             rld_we,
    input logic [NUM_CH-1:0]             cnt_we,
    input logic [NUM_CH-1:0]             ctrl_we
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        assert_bad_code_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (psc[g] > 3'd4) |-> !tick[g]);

        assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !cnt_we[g]) |=> (count[g] == $past(count[g])));

        assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && count[g] != '0 && !cnt_we[g]) |=> (count[g] == $past(count[g]) - 1'b1));

        assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && count[g] == '0 && !cnt_we[g] && !rld_we[g])
                |=> (count[g] == $past(reload[g])) && flag[g]);

        assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> ($past(tick[g]) && $past(count[g]) == '0));

        assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !ctrl_we[g]) |=> flag[g]);
    end

endmodule

bind tick_timer_unit tmr_checker #(.NUM_CH(NUM_CH)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .count   (ch_count),
    .reload  (ch_reload),
    .psc     (ch_psc),
    .run     (ch_run),
    .tick    (ch_tick),
    .flag    (ch_flag),
    .rld_we  (ch_rld_we),
    .cnt_we  (ch_cnt_we),
    .ctrl_we (ch_ctrl_we)
);

// File: tb/tick_timer_unit_test.sv
`timescale 1ns/1ps
module tick_timer_unit_test;

    localparam int NCH = 3;
    localparam int AW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = 2'd2;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NCH-1:0] irq;

    int errors = 0;
    int checks = 0;
    int edges  = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    tick_timer_unit #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1;
        bus_addr = AW'(addr); bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        edges = 0;
    endtask

    task automatic rdx(input int addr, input logic [1:0] sz, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0;
        bus_addr = AW'(addr); bus_size = sz;
        #0.5;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wait_to(input int target);
        while (edges < target) begin
            @(negedge clk);
            edges++;
        end
    endtask

    function automatic logic [31:0] exp_count(input int v, input int r, input int t);
        if (t <= v) return 32'(v - t);
        return 32'(r - ((t - v - 1) % (r + 1)));
    endfunction

    initial begin
        #(150000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        rdx(4, 2'd2, rd);  check("R1 start", rd, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            rdx(8 + 12*c, 2'd2, rd);  check("R1 reload", rd, 32'h0);
            rdx(12 + 12*c, 2'd2, rd); check("R1 count", rd, 32'h0);
            rdx(16 + 12*c, 2'd1, rd); check("R1 ctrl", rd, 32'h0);
        end

        // R4 R6 R7 R9 R11 sweep: every channel, every valid code
        for (int c = 0; c < NCH; c++) begin
            for (int code = 0; code < 5; code++) begin
                int base;
                int dv;
                base = 8 + 12*c;
                dv = 4 << (2*code);
                wr(base + 8, 2'd1, 32'(code) | 32'h20);
                wr(base, 2'd2, 32'd2);
                wr(base + 4, 2'd2, 32'd3);
                wr(4, 2'd0, 32'(1 << c));
                wait_to(3*dv - 1);
                rdx(base + 4, 2'd2, rd); check("R4 count t2", rd, exp_count(3, 2, 2));
                wait_to(4*dv - 1);
                rdx(base + 4, 2'd2, rd); check("R6 count t3", rd, exp_count(3, 2, 3));
                rdx(base + 8, 2'd1, rd); check("R7 flag before wrap", rd & 32'h100, 32'h0);
                check("R9 irq before wrap", 32'(irq), 32'h0);
                wait_to(4*dv);
                rdx(base + 4, 2'd2, rd); check("R7 count wrap", rd, exp_count(3, 2, 4));
                rdx(base + 8, 2'd1, rd); check("R7 flag at wrap", rd & 32'h100, 32'h100);
                check("R11 irq only own", 32'(irq), 32'(1 << c));
                wait_to(7*dv);
                rdx(base + 4, 2'd2, rd); check("R7 periodic", rd, exp_count(3, 2, 7));
                wr(4, 2'd0, 32'h0);
                wr(base + 8, 2'd1, 32'(code));
                check("R9 irq cleared", 32'(irq), 32'h0);
            end
        end

        // R2 R3 map and access widths
        wr(20, 2'd2, 32'hA5A5_1234);
        wr(22, 2'd0, 32'h0000_007E);
        rdx(20, 2'd2, rd); check("R3 byte write lane2", rd, 32'hA57E_1234);
        rdx(22, 2'd1, rd); check("R3 half read", rd, 32'h0000_A57E);
        rdx(20, 2'd0, rd); check("R3 byte read", rd, 32'h0000_0034);
        rdx(8, 2'd2, rd);  check("R2 ch0 reload untouched", rd, 32'h2);
        wr(60, 2'd2, 32'hFFFF_FFFF);
        rdx(60, 2'd2, rd); check("R2 unmapped", rd, 32'h0);
        rdx(0, 2'd2, rd);  check("R2 offset0", rd, 32'h0);

        // R11 start bits above NUM_CH
        wr(4, 2'd0, 32'hFF);
        rdx(4, 2'd2, rd); check("R11 start readback", rd, 32'h7);
        wr(4, 2'd0, 32'h0);
        rdx(4, 2'd2, rd); check("R11 all stopped", rd, 32'h0);

        // R5 invalid code
        wr(16, 2'd1, 32'h5);
        wr(12, 2'd2, 32'd10);
        wr(4, 2'd0, 32'h1);
        wait_to(50);
        rdx(12, 2'd2, rd); check("R5 code5 holds", rd, 32'd10);
        wr(4, 2'd0, 32'h0);

        // R6 halted hold and write
        wr(36, 2'd2, 32'h55);
        wait_to(40);
        rdx(36, 2'd2, rd); check("R6 halted hold", rd, 32'h55);

        // R6 free-running inverse
        wr(16, 2'd1, 32'h0);
        wr(8, 2'd2, 32'hFFFF_FFFF);
        wr(12, 2'd2, 32'hFFFF_FFFF);
        wr(4, 2'd0, 32'h1);
        wait_to(41);
        rdx(12, 2'd2, rd); check("R6 inverse elapsed", ~rd, 32'd10);
        wr(4, 2'd0, 32'h0);

        // R8 R9 flag handling on channel 1
        wr(28, 2'd1, 32'h20);
        wr(20, 2'd2, 32'h0);
        wr(24, 2'd2, 32'h0);
        wr(4, 2'd0, 32'h2);
        wait_to(6);
        wr(4, 2'd0, 32'h0);
        rdx(28, 2'd1, rd); check("R8 flag set", rd, 32'h120);
        check("R9 irq high", 32'(irq), 32'h2);
        wr(28, 2'd0, 32'h20);
        rdx(28, 2'd1, rd); check("R8 lane0 write keeps flag", rd, 32'h120);
        wr(28, 2'd1, 32'h120);
        rdx(28, 2'd1, rd); check("R8 write one keeps flag", rd, 32'h120);
        wr(29, 2'd0, 32'h0);
        rdx(28, 2'd1, rd); check("R8 clear flag", rd, 32'h20);
        check("R9 irq low", 32'(irq), 32'h0);

        // R10 prescaler phase reset on start
        wr(12, 2'd2, 32'd100);
        wr(4, 2'd0, 32'h1);
        wait_to(1);
        wr(4, 2'd0, 32'h0);
        wr(4, 2'd0, 32'h1);
        wait_to(3);
        rdx(12, 2'd2, rd); check("R10 no early tick", rd, 32'd100);
        wait_to(4);
        rdx(12, 2'd2, rd); check("R10 tick after full period", rd, 32'd99);
        wr(4, 2'd0, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule